// File: doc/BRIEF.md
# ADC Test Pattern Generator

This block sits on the 16-bit sample path of a data converter, just ahead of the output formatter. Each accepted sample produces one registered 16-bit output word, chosen by a 3-bit mode select. The word is either the live converter sample or a synthetic pattern meant for checking the capture logic downstream. Five patterns are available: a constant low word, a constant high word, a checkerboard that flips every sample, a counting ramp, and a fixed word built from two byte registers.

A sample is accepted on each clock where `smp_valid` is high. Stateful patterns advance only on accepted samples. A pattern counts as "newly selected" when the select value of an accepted sample differs from the select value of the previous accepted sample. After reset, the previous select value is taken to be live mode (000). The output word and its strobe appear one clock after the sample is accepted.

Top module: `adc_pattern_gen`

## Requirements
- R1: Select values 000, 110 and 111 put the input sample on `out_data` unchanged, one clock after it is accepted.
- R2: Select 001 yields 0x0000 for every accepted sample.
- R3: Select 010 yields 0xFFFF for every accepted sample.
- R4: Select 011 yields 0xAAAA on the first accepted sample after the mode is newly selected, then alternates between 0x5555 and 0xAAAA on each further accepted sample. Odd bit positions are set in 0xAAAA.
- R5: Select 100 yields 0x0000 on the first accepted sample after the mode is newly selected, then a value one higher on each further accepted sample.
- R6: The ramp wraps from 0xFFFF to 0x0000 and keeps counting.
- R7: Select 101 yields the word whose bits 15:8 are `cust_hi` and whose bits 7:0 are `cust_lo`, both sampled in the accepting clock.
- R8: `out_valid` is high exactly one clock after each clock with `smp_valid` high. On clocks where `smp_valid` is low, `out_data` keeps its value and the checkerboard and ramp do not advance.
- R9: Synchronous reset clears `out_data` and `out_valid` to zero and treats the previous select value as 000, so the first checkerboard or ramp after reset starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Pattern select |
| smp_data | input | 16 | Live converter sample |
| smp_valid | input | 1 | Sample accepted in this clock |
| cust_lo | input | 8 | Custom word, low byte |
| cust_hi | input | 8 | Custom word, high byte |
| out_data | output | 16 | Registered output word |
| out_valid | output | 1 | Output word strobe |

## Verification
Two events can land on the same accepted sample: a mode switch and the restart of a stateful pattern. This happens when the checkerboard or the ramp is reselected straight after another mode, including after a pause in `smp_valid`. The bench provokes this by switching modes back and forth around idle gaps and around a reset. A cycle-accurate behavioural model, compared on every clock, judges whether the first word is the start value or the continuation of the earlier sequence.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [2:0] {
    SEL_LIVE   = 3'b000,
    SEL_ZERO   = 3'b001,
    SEL_ONES   = 3'b010,
    SEL_CHECK  = 3'b011,
    SEL_RAMP   = 3'b100,
    SEL_CUSTOM = 3'b101,
    SEL_RSV6   = 3'b110,
    SEL_RSV7   = 3'b111
  } tpg_sel_e;
endpackage

// File: rtl/tpg_ramp.sv
module tpg_ramp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         restart,
  output logic [W-1:0] word
);
  logic [W-1:0] cnt_q;

  // word presented for the current sample; a restart overrides the count
  assign word = restart ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= word + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/tpg_checker_word.sv
module tpg_checker_word #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         restart,
  output logic [W-1:0] word
);
  logic phase_q;
  logic phase_cur;

  assign phase_cur = restart ? 1'b0 : phase_q;

  // phase 0: odd bits set, even bits clear
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i % 2 == 1) begin : g_odd
      assign word[i] = ~phase_cur;
    end else begin : g_even
      assign word[i] = phase_cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= 1'b0;
    else if (step) phase_q <= ~phase_cur;
  end
endmodule

// File: rtl/tpg_select.sv
module tpg_select
  import tpg_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  tpg_sel_e        sel,
  input  logic [W-1:0]    live,
  input  logic [W-1:0]    check_word,
  input  logic [W-1:0]    ramp_word,
  input  logic [BW-1:0]   byte_lo,
  input  logic [BW-1:0]   byte_hi,
  output logic [W-1:0]    word
);
  logic [W-1:0] custom_word;

  assign custom_word = {byte_hi, byte_lo};

  always_comb begin
    unique case (sel)
      SEL_ZERO:   word = '0;
      SEL_ONES:   word = '1;
      SEL_CHECK:  word = check_word;
      SEL_RAMP:   word = ramp_word;
      SEL_CUSTOM: word = custom_word;
      default:    word = live;
    endcase
  end
endmodule

// File: rtl/adc_pattern_gen.sv
module adc_pattern_gen
  import tpg_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SEL_W-1:0]      mode_sel,
  input  logic [2*BYTE_W-1:0]   smp_data,
  input  logic                  smp_valid,
  input  logic [BYTE_W-1:0]     cust_lo,
  input  logic [BYTE_W-1:0]     cust_hi,
  output logic [2*BYTE_W-1:0]   out_data,
  output logic                  out_valid
);
  localparam int DW = 2 * BYTE_W;

  tpg_sel_e      sel_e;
  tpg_sel_e      last_sel_q;
  logic          fresh;
  logic [DW-1:0] ramp_word;
  logic [DW-1:0] check_word;
  logic [DW-1:0] next_word;

  assign sel_e = tpg_sel_e'(mode_sel);
  assign fresh = (sel_e != last_sel_q);

  tpg_ramp #(.W(DW)) i_ramp (
    .clk     (clk),
    .rst     (rst),
    .step    (smp_valid && (sel_e == SEL_RAMP)),
    .restart (fresh),
    .word    (ramp_word)
  );

  tpg_checker_word #(.W(DW)) i_check (
    .clk     (clk),
    .rst     (rst),
    .step    (smp_valid && (sel_e == SEL_CHECK)),
    .restart (fresh),
    .word    (check_word)
  );

  tpg_select #(.W(DW), .BW(BYTE_W)) i_sel (
    .sel        (sel_e),
    .live       (smp_data),
    .check_word (check_word),
    .ramp_word  (ramp_word),
    .byte_lo    (cust_lo),
    .byte_hi    (cust_hi),
    .word       (next_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      last_sel_q <= SEL_LIVE;
      out_data   <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) begin
        last_sel_q <= sel_e;
        out_data   <= next_word;
      end
    end
  end
endmodule

// File: rtl/tpg_assert.sv
module tpg_assert (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  mode_sel,
  input logic [15:0] smp_data,
  input logic        smp_valid,
  input logic [7:0]  cust_lo,
  input logic [7:0]  cust_hi,
  input logic [15:0] out_data,
  input logic        out_valid
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) smp_valid |=> out_valid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !smp_valid |=> !out_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !smp_valid |=> $stable(out_data)); // R8
  AST_PASS_LIVE: assert property (@(posedge clk) disable iff (rst)
    smp_valid && (mode_sel == 3'd0 || mode_sel == 3'd6 || mode_sel == 3'd7) |=> out_data == $past(smp_data)); // R1
  AST_ALL_ZERO: assert property (@(posedge clk) disable iff (rst) smp_valid && mode_sel == 3'd1 |=> out_data == 16'h0000); // R2
  AST_ALL_ONES: assert property (@(posedge clk) disable iff (rst) smp_valid && mode_sel == 3'd2 |=> out_data == 16'hFFFF); // R3
  AST_CHECK_SET: assert property (@(posedge clk) disable iff (rst)
    smp_valid && mode_sel == 3'd3 |=> (out_data == 16'hAAAA || out_data == 16'h5555)); // R4
  AST_CHECK_START: assert property (@(posedge clk) disable iff (rst)
    smp_valid && mode_sel == 3'd3 && $past(smp_valid) && $past(mode_sel) != 3'd3 |=> out_data == 16'hAAAA); // R4
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    smp_valid && mode_sel == 3'd4 && $past(!rst && smp_valid && mode_sel == 3'd4)
    |=> out_data == 16'($past(out_data) + 16'd1)); // R6
  AST_RAMP_START: assert property (@(posedge clk) disable iff (rst)
    smp_valid && mode_sel == 3'd4 && $past(smp_valid) && $past(mode_sel) != 3'd4 |=> out_data == 16'h0000); // R5
  AST_CUSTOM_WORD: assert property (@(posedge clk) disable iff (rst)
    smp_valid && mode_sel == 3'd5 |=> out_data == {$past(cust_hi), $past(cust_lo)}); // R7
endmodule

bind adc_pattern_gen tpg_assert i_tpg_assert (
  .clk       (clk),
  .rst       (rst),
  .mode_sel  (mode_sel),
  .smp_data  (smp_data),
  .smp_valid (smp_valid),
  .cust_lo   (cust_lo),
  .cust_hi   (cust_hi),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/test_adc_pattern_gen.sv
`timescale 1ns/1ps
module test_adc_pattern_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_sel = 3'd0;
  logic [15:0] smp_data = 16'h0;
  logic        smp_valid = 1'b0;
  logic [7:0]  cust_lo = 8'h0;
  logic [7:0]  cust_hi = 8'h0;
  logic [15:0] out_data;
  logic        out_valid;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model state
  int m_last = 0;
  int m_ramp = 0;
  int m_phase = 0;
  int exp_data = 0;
  bit exp_valid = 0;

  always #2 clk = ~clk;

  adc_pattern_gen i_adc_pattern_gen (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .smp_data(smp_data),
    .smp_valid(smp_valid), .cust_lo(cust_lo), .cust_hi(cust_hi),
    .out_data(out_data), .out_valid(out_valid)
  );

  function automatic string tag_of(int s);
    case (s)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5/R6";
      5: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    m_last = 0; m_ramp = 0; m_phase = 0; exp_data = 0; exp_valid = 0;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(int s, int d, bit v, int lo = 0, int hi = 0, string why = "");
    int ph;
    int r;
    bit fresh;
    string t;
    mode_sel = 3'(s); smp_data = 16'(d); smp_valid = v;
    cust_lo = 8'(lo); cust_hi = 8'(hi);
    @(posedge clk);
    exp_valid = v;
    if (v) begin
      fresh = (s != m_last);
      case (s)
        1: exp_data = 0;
        2: exp_data = 'hFFFF;
        3: begin
             ph = fresh ? 0 : m_phase;
             exp_data = ph ? 'h5555 : 'hAAAA;
             m_phase = 1 - ph;
           end
        4: begin
             r = fresh ? 0 : m_ramp;
             exp_data = r;
             m_ramp = (r + 1) & 'hFFFF;
           end
        5: exp_data = (hi << 8) | lo;
        default: exp_data = d & 'hFFFF;
      endcase
      m_last = s;
    end
    @(negedge clk);
    t = v ? tag_of(s) : "R8";
    if (why != "") t = why;
    check(t, int'(out_data), exp_data);
    check("R8", int'(out_valid), int'(exp_valid));
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_valid = 1'b0; mode_sel = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R9", int'(out_data), 0);
    check("R9", int'(out_valid), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: live pass-through including the unused codes
    step(0, 'h1234, 1); step(0, 'hFEDC, 1); step(6, 'h0F0F, 1); step(7, 'h8001, 1);
    // R2, R3
    step(1, 'h5A5A, 1); step(2, 'h0000, 1); step(1, 'hFFFF, 1);
    // R4: checkerboard, a gap that must not advance it (R8), then continuation
    step(3, 0, 1); step(3, 0, 1); step(3, 0, 1);
    step(3, 'h7777, 0); step(0, 'h1111, 0);
    step(3, 0, 1); step(3, 0, 1);
    // reselection after another mode restarts at 0xAAAA
    step(0, 'h4242, 1); step(3, 0, 1, 0, 0, "R4"); step(3, 0, 1);
    // R5: ramp, gap, reselect restarts
    for (int i = 0; i < 10; i++) step(4, 0, 1);
    step(4, 0, 0); step(4, 0, 1);
    step(5, 0, 1, 'h34, 'h12); step(4, 0, 1, 0, 0, "R5");
    for (int i = 0; i < 5; i++) step(4, 0, 1);
    // R7: custom word with the bytes changing
    step(5, 0, 1, 'hCD, 'hAB); step(5, 0, 1, 'h00, 'hFF); step(5, 0, 1, 'h80, 'h01);
    // R6: full ramp lap and wrap
    step(0, 0, 1);
    for (int i = 0; i < 65540; i++) step(4, 0, 1, 0, 0, (i >= 65534) ? "R6" : "");
    // R9: reset mid-ramp, the first ramp afterwards starts at zero
    do_reset();
    step(4, 0, 1, 0, 0, "R9"); step(4, 0, 1); step(3, 0, 1, 0, 0, "R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule